// File: doc/BRIEF.md
# Interrupt Aggregator with Doorbell Injection

This block merges a fixed population of interrupt sources into a single level-sensitive interrupt line. Part of the population arrives on wires. The rest arrives as messages: a bus agent writes a source number to a doorbell register, and the block latches an event for that source. Wired and message sources share one flat index space. Each index has one latched cause bit and one mask bit, and software sees them as packed 32-bit words on a simple register bus.

Software masks everything at start-up, then unmasks the sources it owns. When the output line rises, the handler reads the cause words and serves the lowest pending index first. It acknowledges a source by writing a one to that bit of the cause word, and loops until no cause bit remains. Wired lines are resynchronised and only their rising edges count, so a line that stays high produces one event.

Top module: `irq_merge_doorbell`

## Requirements
- R1: The block has 64 sources. Indices 0 to 20 take events from `wired_in[20:0]`, bit i feeding index i. Indices 21 to 63 take events only from the doorbell. A doorbell write may name any index from 0 to 63, wired ones included.
- R2: After reset every cause bit is 0, every mask bit is 1, and `irq_out` is 0.
- R3: `bus_rdata` follows `bus_addr` in the same cycle. Offset 0x00 returns cause bits 31..0 and offset 0x04 returns cause bits 63..32, with source i at bit i%32 of word i/32. Offsets 0x20 and 0x24 return the mask bits in the same layout.
- R4: A write to 0x20 or 0x24 replaces that whole mask word, taking effect at the sampling clock edge. A mask bit of 1 disables its source and a mask bit of 0 enables it.
- R5: The cause words are write-one-to-clear. Each 1 in the write data to 0x00 or 0x04 clears the matching cause bit. Each 0 leaves its bit unchanged.
- R6: A write of value N to offset 0x30 sets cause bit N at the sampling edge when N < 64, treating the data as an unsigned 32-bit number. Any value of 64 or more changes nothing.
- R7: A rising edge on `wired_in[i]` sets cause bit i at the third clock edge after the input changes (two synchroniser stages, then the edge register). A line held high does not set the bit again after it is cleared. When a set and a clear hit the same bit in the same cycle, the bit ends set.
- R8: `irq_out` equals the OR over all sources of (cause AND NOT mask) as it stood before the previous clock edge. It is one register behind the cause and mask state. Masked sources still latch their cause bit.
- R9: Reads of any offset other than 0x00, 0x04, 0x20 and 0x24 return zero, including 0x30. Writes to offsets other than those four and 0x30 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wired_in | input | 21 | Asynchronous wired interrupt lines, one per low source index |
| bus_wr | input | 1 | Register write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Registered aggregate interrupt |

## Verification
The bench builds the block with its default parameters: 21 wired lines, 43 message sources, 32-bit words and two synchroniser stages. This gives two cause words and two mask words, so the split between the low and high word, and the boundary at index 63 against 64, are both reached. With two synchroniser stages, a wired edge can be made to land in exactly the same cycle as a write-one-to-clear of that bit. This lets the bench check that the set wins.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Register layout; software relies on these offsets
  localparam int unsigned CAUSE_BASE = 32'h00;
  localparam int unsigned MASK_BASE  = 32'h20;
  localparam int unsigned DOORBELL   = 32'h30;
  localparam int unsigned WORD_BYTES = 4;

  // Byte offset of word k of a register group
  function automatic int unsigned reg_ofs(input int unsigned base, input int unsigned k);
    return base + WORD_BYTES * k;
  endfunction

  // Doorbell payload names an existing source
  function automatic logic doorbell_valid(input logic [31:0] value, input int unsigned n_src);
    return value < n_src;
  endfunction

endpackage

// File: rtl/irqagg_wire_edge.sv
module irqagg_wire_edge #(
  parameter int unsigned WIDTH       = 21,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lines_in,
  output logic [WIDTH-1:0] rise_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    logic                   last;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], lines_in[g]};
        last  <= chain[SYNC_STAGES-1];
      end
    end

    assign rise_o[g] = chain[SYNC_STAGES-1] & ~last;
  end

  // An edge pulse lasts exactly one cycle
  assert_rise_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irqagg_regif.sv
module irqagg_regif
  import irqagg_pkg::*;
#(
  parameter int unsigned N_SRC   = 64,
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [N_SRC-1:0]    cause_q,
  input  logic [N_SRC-1:0]    mask_q,
  output logic [N_SRC-1:0]    clr_vec,
  output logic [N_SRC-1:0]    db_set,
  output logic [N_WORDS-1:0]  mask_we,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int unsigned PAD_W = N_WORDS * DATA_W;

  logic [PAD_W-1:0] cause_pad;
  logic [PAD_W-1:0] mask_pad;
  logic             db_hit;
  logic             db_ok;
  logic             addr_mapped;

  always_comb begin
    cause_pad = '0;
    mask_pad  = '0;
    cause_pad[N_SRC-1:0] = cause_q;
    mask_pad[N_SRC-1:0]  = mask_q;
  end

  assign db_hit = bus_wr && (bus_addr == ADDR_W'(DOORBELL));
  assign db_ok  = doorbell_valid(32'(bus_wdata), N_SRC);

  // Write decode: W1C clear vector, mask word enables, doorbell one-hot
  always_comb begin
    clr_vec     = '0;
    db_set      = '0;
    mask_we     = '0;
    addr_mapped = (bus_addr == ADDR_W'(DOORBELL));
    for (int k = 0; k < N_WORDS; k++) begin
      if (bus_addr == ADDR_W'(reg_ofs(CAUSE_BASE, k)) ||
          bus_addr == ADDR_W'(reg_ofs(MASK_BASE, k)))
        addr_mapped = 1'b1;
      mask_we[k] = bus_wr && (bus_addr == ADDR_W'(reg_ofs(MASK_BASE, k)));
    end
    for (int i = 0; i < N_SRC; i++) begin
      clr_vec[i] = bus_wr && (bus_addr == ADDR_W'(reg_ofs(CAUSE_BASE, i / DATA_W)))
                   && bus_wdata[i % DATA_W];
      db_set[i]  = db_hit && db_ok && (bus_wdata == DATA_W'(i));
    end
  end

  // Read mux; unmapped offsets give zero
  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (bus_addr == ADDR_W'(reg_ofs(CAUSE_BASE, k)))
        bus_rdata = cause_pad[k*DATA_W +: DATA_W];
      if (bus_addr == ADDR_W'(reg_ofs(MASK_BASE, k)))
        bus_rdata = mask_pad[k*DATA_W +: DATA_W];
    end
  end

  assert_db_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_hit && (bus_wdata >= DATA_W'(N_SRC))) |-> (db_set == '0));

  assert_db_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(db_set));

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_mapped) |-> (clr_vec == '0 && mask_we == '0 && db_set == '0));

endmodule

// File: rtl/irqagg_src_bank.sv
module irqagg_src_bank #(
  parameter int unsigned N_SRC   = 64,
  parameter int unsigned N_WIRED = 21,
  parameter int unsigned N_WORDS = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WIRED-1:0] wired_rise,
  input  logic [N_SRC-1:0]   db_set,
  input  logic [N_SRC-1:0]   clr_vec,
  input  logic [N_WORDS-1:0] mask_we,
  input  logic [DATA_W-1:0]  mask_wdata,
  output logic [N_SRC-1:0]   cause_q,
  output logic [N_SRC-1:0]   mask_q,
  output logic               irq_q
);

  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] cause_d;
  logic [N_SRC-1:0] mask_d;
  logic             pending;

  always_comb begin
    set_vec = db_set;
    set_vec[N_WIRED-1:0] = db_set[N_WIRED-1:0] | wired_rise;
  end

  // New events take priority over a clear in the same cycle
  assign cause_d = (cause_q & ~clr_vec) | set_vec;

  always_comb begin
    mask_d = mask_q;
    for (int i = 0; i < N_SRC; i++)
      if (mask_we[i / DATA_W]) mask_d[i] = mask_wdata[i % DATA_W];
  end

  assign pending = |(cause_q & ~mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '1;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      irq_q   <= pending;
    end
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((cause_q & $past(clr_vec & ~set_vec)) == '0));

  assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((cause_q ^ $past(cause_q)) & ~$past(set_vec | clr_vec)) == '0));

  assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |=> !irq_q);

endmodule

// File: rtl/irq_merge_doorbell.sv
module irq_merge_doorbell #(
  parameter int unsigned N_WIRED     = 21,
  parameter int unsigned N_MSG       = 43,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WIRED-1:0] wired_in,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);

  localparam int unsigned N_SRC   = N_WIRED + N_MSG;
  localparam int unsigned N_WORDS = (N_SRC + DATA_W - 1) / DATA_W;

  logic [N_WIRED-1:0] wired_rise;
  logic [N_SRC-1:0]   cause_q;
  logic [N_SRC-1:0]   mask_q;
  logic [N_SRC-1:0]   clr_vec;
  logic [N_SRC-1:0]   db_set;
  logic [N_WORDS-1:0] mask_we;

  irqagg_wire_edge #(.WIDTH(N_WIRED), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines_in(wired_in), .rise_o(wired_rise)
  );

  irqagg_regif #(.N_SRC(N_SRC), .N_WORDS(N_WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cause_q(cause_q), .mask_q(mask_q), .clr_vec(clr_vec), .db_set(db_set),
    .mask_we(mask_we), .bus_rdata(bus_rdata)
  );

  irqagg_src_bank #(.N_SRC(N_SRC), .N_WIRED(N_WIRED), .N_WORDS(N_WORDS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wired_rise(wired_rise), .db_set(db_set), .clr_vec(clr_vec),
    .mask_we(mask_we), .mask_wdata(bus_wdata), .cause_q(cause_q), .mask_q(mask_q),
    .irq_q(irq_out)
  );

  // Output stays low for the cycle after reset releases
  assert_reset_quiet_R2: assert property (@(posedge clk) $rose(rst_n) |-> !irq_out);

endmodule

// File: tb/irq_merge_doorbell_bench.sv
`timescale 1ns/1ps
module irq_merge_doorbell_bench;
  localparam int NW = 21;
  localparam int NS = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [NW-1:0] wired;
  logic          bus_wr;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  wire  [31:0]   bus_rdata;
  wire           irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_merge_doorbell u_irq_merge_doorbell (
    .clk(clk), .rst_n(rst_n), .wired_in(wired), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // Behavioural reference state
  bit m_cause[NS];
  bit m_mask[NS];
  bit m_s1[NW], m_s2[NW], m_prev[NW];
  bit m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 0;
    for (int b = 0; b < 32; b++) begin
      if (a == 8'h00) r[b] = m_cause[b];
      if (a == 8'h04) r[b] = m_cause[32+b];
      if (a == 8'h20) r[b] = m_mask[b];
      if (a == 8'h24) r[b] = m_mask[32+b];
    end
    return r;
  endfunction

  always @(posedge clk) begin : model
    bit nxt[NS];
    bit any;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin m_cause[i] <= 0; m_mask[i] <= 1; end
      for (int i = 0; i < NW; i++) begin m_s1[i] <= 0; m_s2[i] <= 0; m_prev[i] <= 0; end
      m_irq <= 0;
    end else begin
      any = 0;
      for (int i = 0; i < NS; i++) begin
        if (m_cause[i] && !m_mask[i]) any = 1;
        nxt[i] = m_cause[i];
      end
      if (bus_wr) begin
        for (int b = 0; b < 32; b++) begin
          if (bus_addr == 8'h00 && bus_wdata[b]) nxt[b] = 0;
          if (bus_addr == 8'h04 && bus_wdata[b]) nxt[32+b] = 0;
          if (bus_addr == 8'h20) m_mask[b] <= bus_wdata[b];
          if (bus_addr == 8'h24) m_mask[32+b] <= bus_wdata[b];
        end
        if (bus_addr == 8'h30 && bus_wdata < 64) nxt[bus_wdata] = 1;
      end
      for (int i = 0; i < NW; i++) begin
        if (m_s2[i] && !m_prev[i]) nxt[i] = 1;
        m_prev[i] <= m_s2[i];
        m_s2[i]   <= m_s1[i];
        m_s1[i]   <= wired[i];
      end
      for (int i = 0; i < NS; i++) m_cause[i] <= nxt[i];
      m_irq <= any;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq_out vs model", {31'b0, irq_out}, {31'b0, m_irq});
      chk("R3 rdata vs model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 0; wired = '0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    idle(4);
    rst_n = 1;
    @(negedge clk);
    chk("R2 irq after reset", {31'b0, irq_out}, 32'h0);
    rd("R2 cause lo reset", 8'h00, 32'h0);
    rd("R2 cause hi reset", 8'h04, 32'h0);
    rd("R2 mask lo reset", 8'h20, 32'hFFFF_FFFF);
    rd("R2 mask hi reset", 8'h24, 32'hFFFF_FFFF);

    wr(8'h30, 21); wr(8'h30, 40); wr(8'h30, 63);
    rd("R6 doorbell 21", 8'h00, 32'h0020_0000);
    rd("R3 high word 40/63", 8'h04, 32'h8000_0100);
    chk("R8 masked stays low", {31'b0, irq_out}, 32'h0);

    wr(8'h24, 32'hFFFF_FEFF);
    idle(2);
    @(negedge clk);
    chk("R8 unmasked 40 raises", {31'b0, irq_out}, 32'h1);
    rd("R4 mask hi readback", 8'h24, 32'hFFFF_FEFF);

    wr(8'h04, 32'h0000_0100);
    rd("R5 w1c clears 40 only", 8'h04, 32'h8000_0000);
    idle(2);
    @(negedge clk);
    chk("R8 drops after clear", {31'b0, irq_out}, 32'h0);

    wr(8'h30, 64); wr(8'h30, 32'h100); wr(8'h30, 32'hFFFF_FFFF);
    rd("R6 out-of-range lo", 8'h00, 32'h0020_0000);
    rd("R6 out-of-range hi", 8'h04, 32'h8000_0000);

    wr(8'h08, 32'hFFFF_FFFF); wr(8'h28, 0); wr(8'h2C, 0); wr(8'h34, 5);
    rd("R9 mask hi untouched", 8'h24, 32'hFFFF_FEFF);
    rd("R9 mask lo untouched", 8'h20, 32'hFFFF_FFFF);
    rd("R9 cause untouched", 8'h00, 32'h0020_0000);
    rd("R9 read 0x08 zero", 8'h08, 32'h0);
    rd("R9 read doorbell zero", 8'h30, 32'h0);
    rd("R9 read 0x28 zero", 8'h28, 32'h0);

    wr(8'h20, 32'hFFFF_FFF7);
    @(posedge clk); #1; wired[3] = 1'b1;
    idle(5);
    rd("R7 wired edge sets 3", 8'h00, 32'h0020_0008);
    @(negedge clk);
    chk("R8 wired 3 unmasked", {31'b0, irq_out}, 32'h1);
    wr(8'h00, 32'h0000_0008);
    idle(5);
    rd("R7 held level no retrigger", 8'h00, 32'h0020_0000);

    // Edge on line 5 lands at the same edge as a W1C of bits 5 and 21
    @(posedge clk); #1; wired[5] = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h0020_0020;
    @(posedge clk); #1; bus_wr = 0;
    rd("R7 set wins over clear", 8'h00, 32'h0000_0020);

    wr(8'h30, 2);
    rd("R1 doorbell on wired index", 8'h00, 32'h0000_0024);
    @(posedge clk); #1; wired[20] = 1'b1;
    idle(5);
    rd("R1 top wired line 20", 8'h00, 32'h0010_0024);

    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule